// File: doc/BRIEF.md
# Dual-Channel Prescaled PWM Controller

This block generates two independent pulse-width modulated outputs from one system clock. Software programs it through a small memory-mapped register window. One shared control word holds a field group for each channel: prescaler code, enable, clock gate and output polarity. Each channel also has its own timing word, which carries an active count and a period-minus-one count.

Each channel divides the system clock by a ratio picked from a fixed, non-power-of-two table. It counts prescaled ticks across the programmed period and drives its output at the active level while the count is below the active count. A new timing word is not applied at once. It is held in a shadow copy and moved into the working counter at the next period boundary, so a running waveform never shows a torn period. While a load is pending, a read-only busy flag per channel is set, and any further timing writes to that channel are dropped.

Top module: `pwmc_top`

## Requirements
- R1: After reset, all registers read as zero and both outputs are high, because the clear polarity bits invert the output and the inactive level is then high.
- R2: The control word is at byte offset 0x0 and channel n's timing word is at 0x4+4n. Channel n's fields in the control word start at bit 15n. Relative to that base: prescaler code [3:0], enable 4, polarity 5, clock gate 6, and three stored-only bits 7, 8, 9. All ten bits read back as written. Writes to bits 28 and 29 are ignored.
- R3: Prescaler code to divide ratio: 0→120, 1→180, 2→240, 3→360, 4→480, 8→12000, 9→24000, 10→36000, 11→48000, 12→72000, 15→1.
- R4: In the timing word, bits [7:0] are the active count D and bits [23:16] are the period-minus-one P. A running channel repeats every (P+1)·ratio clocks and is active for min(D, P+1)·ratio clocks of each period.
- R5: With polarity bit 1, the active level is high. With polarity bit 0, the active level is low and the output is inverted.
- R6: A channel runs only while both its enable and clock-gate bits are set. Otherwise its output holds the inactive level and its counters return to zero, so a re-enabled channel starts a fresh period with its output active from the first clock.
- R7: Bit 28+n of the control word reads 1 from the clock after an accepted timing write on channel n until that value is loaded. Loading happens at the end of the current period, or on the next clock if the channel is not running.
- R8: A timing write to a channel whose busy flag is set is ignored. The timing word reads back the earlier value and the waveform follows the earlier value.
- R9: An active count of 0 holds the inactive level for the whole period. An active count above P holds the active level for the whole period.
- R10: A reserved prescaler code (5, 6, 7, 13, 14) keeps the channel stopped with its output at the inactive level, even when it is enabled and gated.
- R11: The two channels run independently, each with its own ratio, period and polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 2 | PWM waveforms, bit n for channel n |

## Verification
The embedded assertions check several properties on every clock. The period counter never passes the working period. Idle channels clear their counters. A pending load survives until a boundary, and it only clears at a boundary or while idle. The shadow copy is frozen while a load is pending. Only the bench's scenarios can show the waveform properties as seen at the pins. These are the duty and period counts for each prescaler ratio, polarity inversion, the saturated duty cases, the stopped state for reserved codes, and the fact that a dropped write never reaches the waveform.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

  localparam int PS_W = 17;   // wide enough for the largest ratio (72000)
  localparam int FLD_W = 10;  // control bits per channel

  // Channel control fields; packed so that code sits in the low bits.
  typedef struct packed {
    logic       keep_bypass;  // bit 9, stored only
    logic       keep_pulse;   // bit 8, stored only
    logic       keep_mode;    // bit 7, stored only
    logic       gate;         // bit 6
    logic       act_hi;       // bit 5
    logic       en;           // bit 4
    logic [3:0] code;         // bits 3:0
  } chan_ctl_t;

  // Divide ratio for a prescaler code; zero marks a reserved code.
  function automatic logic [PS_W-1:0] ps_ratio(input logic [3:0] code);
    case (code)
      4'd0:    ps_ratio = PS_W'(120);
      4'd1:    ps_ratio = PS_W'(180);
      4'd2:    ps_ratio = PS_W'(240);
      4'd3:    ps_ratio = PS_W'(360);
      4'd4:    ps_ratio = PS_W'(480);
      4'd8:    ps_ratio = PS_W'(12000);
      4'd9:    ps_ratio = PS_W'(24000);
      4'd10:   ps_ratio = PS_W'(36000);
      4'd11:   ps_ratio = PS_W'(48000);
      4'd12:   ps_ratio = PS_W'(72000);
      4'd15:   ps_ratio = PS_W'(1);
      default: ps_ratio = '0;
    endcase
  endfunction

endpackage

// File: rtl/pwmc_prescaler.sv
module pwmc_prescaler
  import pwmc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] ratio,
  output logic            tick
);

  logic [PS_W-1:0] div_cnt;

  // >= rather than == so that a ratio lowered mid-count still wraps promptly
  assign tick = run && (div_cnt >= ratio - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)              div_cnt <= '0;
    else if (!run || tick)   div_cnt <= '0;
    else                     div_cnt <= div_cnt + 1'b1;
  end

  AST_PS_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> div_cnt == '0); // R6
  AST_PS_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> div_cnt == '0); // R3

endmodule

// File: rtl/pwmc_channel.sv
module pwmc_channel #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             act_hi,
  input  logic             prd_we,
  input  logic [CNT_W-1:0] wr_dty,
  input  logic [CNT_W-1:0] wr_per,
  output logic             pending,
  output logic [CNT_W-1:0] shd_dty,
  output logic [CNT_W-1:0] shd_per,
  output logic             pwm
);

  logic [CNT_W-1:0] pcnt, work_dty, work_per;
  logic             boundary, take, active;

  assign boundary = tick && (pcnt == work_per);
  assign take     = pending && (boundary || !run);
  assign active   = run && (pcnt < work_dty);
  assign pwm      = act_hi ? active : !active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt     <= '0;
      pending  <= 1'b0;
      shd_dty  <= '0;
      shd_per  <= '0;
      work_dty <= '0;
      work_per <= '0;
    end else begin
      if (!run)          pcnt <= '0;
      else if (boundary) pcnt <= '0;
      else if (tick)     pcnt <= pcnt + 1'b1;

      if (take)          pending <= 1'b0;
      else if (prd_we)   pending <= 1'b1;

      if (prd_we && !pending) begin
        shd_dty <= wr_dty;
        shd_per <= wr_per;
      end

      if (take) begin
        work_dty <= shd_dty;
        work_per <= shd_per;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= work_per); // R4
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pcnt == '0); // R6
  AST_HOLD_TILL_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    pending && run && !boundary |=> pending); // R7
  AST_LOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> $past(boundary || !run)); // R7
  AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    pending && prd_we |=> $stable(shd_dty) && $stable(shd_per)); // R8

endmodule

// File: rtl/pwmc_top.sv
module pwmc_top
  import pwmc_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int CNT_W  = 8,
  parameter int STRIDE = 15,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    pwm_out
);

  localparam int RDY_BIT = 28;
  localparam int PER_LSB = 16;

  chan_ctl_t        ctl     [NCH];
  logic [NCH-1:0]   pending;
  logic [CNT_W-1:0] shd_dty [NCH];
  logic [CNT_W-1:0] shd_per [NCH];

  logic ctl_hit;
  assign ctl_hit = bus_we && (bus_addr == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < NCH; n++) ctl[n] <= '0;
    end else if (ctl_hit) begin
      for (int n = 0; n < NCH; n++) ctl[n] <= bus_wdata[n*STRIDE +: FLD_W];
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam logic [ADDR_W-1:0] PRD_ADDR = ADDR_W'(4 * (n + 1));
    logic            run, tick, prd_we;
    logic [PS_W-1:0] ratio;

    assign ratio  = ps_ratio(ctl[n].code);
    assign run    = ctl[n].en && ctl[n].gate && (ratio != '0);
    assign prd_we = bus_we && (bus_addr == PRD_ADDR);

    pwmc_prescaler u_ps (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .ratio (ratio),
      .tick  (tick)
    );

    pwmc_channel #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .tick    (tick),
      .act_hi  (ctl[n].act_hi),
      .prd_we  (prd_we),
      .wr_dty  (bus_wdata[CNT_W-1:0]),
      .wr_per  (bus_wdata[PER_LSB +: CNT_W]),
      .pending (pending[n]),
      .shd_dty (shd_dty[n]),
      .shd_per (shd_per[n]),
      .pwm     (pwm_out[n])
    );

    AST_RESERVED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio == '0) |-> !tick); // R10
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == '0) begin
      for (int n = 0; n < NCH; n++) begin
        bus_rdata[n*STRIDE +: FLD_W] = ctl[n];
        bus_rdata[RDY_BIT + n]       = pending[n];
      end
    end else begin
      for (int n = 0; n < NCH; n++) begin
        if (bus_addr == ADDR_W'(4 * (n + 1))) begin
          bus_rdata[CNT_W-1:0]         = shd_dty[n];
          bus_rdata[PER_LSB +: CNT_W]  = shd_per[n];
        end
      end
    end
  end

endmodule

// File: tb/tb_pwmc_top.sv
module tb_pwmc_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  pwm_out;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [31:0] ctlv = '0;

  pwmc_top dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 190000)", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic int ratio_of(input int code);
    int t[16] = '{120, 180, 240, 360, 480, 0, 0, 0,
                  12000, 24000, 36000, 48000, 72000, 0, 0, 1};
    return t[code];
  endfunction

  function automatic int exp_active(input int p, input int d, input int r);
    return ((d < p + 1) ? d : p + 1) * r;
  endfunction

  function automatic logic [9:0] fld(input int code, input bit en, input bit act, input bit gate);
    return {3'b000, gate, act, en, 4'(code)};
  endfunction

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_ch(input int ch, input logic [9:0] f);
    ctlv[ch*15 +: 10] = f;
    wr(4'h0, ctlv);
  endtask

  // count cycles in which channel ch sits at the level 'lvl'
  task automatic count_lvl(input int ch, input int win, input bit lvl, output int n);
    n = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (pwm_out[ch] == lvl) n++;
    end
  endtask

  // program with the channel stopped, then start and measure one period window
  task automatic run_case(input string tag, input int ch, input int code,
                          input int p, input int d, input bit act);
    int n, r;
    r = ratio_of(code);
    set_ch(ch, fld(code, 1'b0, act, 1'b0));
    wr(4'(4 + 4*ch), {8'h0, 8'(p), 8'h0, 8'(d)});
    repeat (2) @(negedge clk);
    set_ch(ch, fld(code, 1'b1, act, 1'b1));
    count_lvl(ch, (p + 1) * r, act, n);
    check(tag, n, exp_active(p, d, r));
  endtask

  initial begin
    logic [31:0] v;
    int n, p, d, code, ch;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'h0, v); check("R1 ctrl reset", v, 0);
    rd(4'h4, v); check("R1 period0 reset", v, 0);
    rd(4'h8, v); check("R1 period1 reset", v, 0);
    check("R1 outputs high", pwm_out, 2'b11);

    // R2 field layout and read-only busy bits
    wr(4'h0, 32'h3000_0000 | (32'h3A3 << 15) | 32'h2C8);
    rd(4'h0, v); check("R2 ctrl readback", v, (32'h3A3 << 15) | 32'h2C8);
    wr(4'h0, 32'h0); ctlv = 0;
    check("R2 stored-only bits leave outputs", pwm_out, 2'b11);

    // R3/R4 each table ratio on small periods
    run_case("R3 code0", 0, 0, 3, 2, 1'b1);
    run_case("R3 code2", 1, 2, 2, 1, 1'b1);
    run_case("R3 code4", 0, 4, 1, 1, 1'b1);
    run_case("R3 code8", 0, 8, 1, 1, 1'b1);
    run_case("R4 code15", 1, 15, 255, 128, 1'b1);

    // R5 inverted polarity: active level is low
    run_case("R5 low active", 0, 15, 19, 7, 1'b0);
    count_lvl(0, 20, 1'b1, n); check("R5 high count inverted", n, 13);

    // R9 saturation
    run_case("R9 duty zero", 0, 15, 9, 0, 1'b1);
    run_case("R9 duty above period", 1, 15, 9, 200, 1'b1);
    run_case("R9 duty equals P+1", 1, 15, 9, 10, 1'b1);

    // R6 gate cleared stops channel; restart starts fresh
    set_ch(0, fld(15, 1'b1, 1'b1, 1'b0));
    count_lvl(0, 30, 1'b1, n); check("R6 gate off inactive", n, 0);
    set_ch(0, fld(15, 1'b0, 1'b1, 1'b0));
    wr(4'h4, {8'h0, 8'd9, 8'h0, 8'd3});
    repeat (2) @(negedge clk);
    set_ch(0, fld(15, 1'b1, 1'b1, 1'b1));
    for (int i = 0; i < 4; i++) begin
      check("R6 restart phase", pwm_out[0], (i < 3) ? 1 : 0);
      @(negedge clk);
    end
    set_ch(0, fld(15, 1'b0, 1'b0, 1'b1));
    check("R6 disabled level inverted", pwm_out[0], 1);

    // R10 reserved code
    set_ch(1, fld(5, 1'b0, 1'b1, 1'b0));
    wr(4'h8, {8'h0, 8'd3, 8'h0, 8'd2});
    repeat (2) @(negedge clk);
    set_ch(1, fld(5, 1'b1, 1'b1, 1'b1));
    count_lvl(1, 40, 1'b1, n); check("R10 reserved stopped", n, 0);
    set_ch(1, fld(13, 1'b1, 1'b1, 1'b1));
    count_lvl(1, 40, 1'b1, n); check("R10 reserved code13", n, 0);
    set_ch(1, fld(15, 1'b0, 1'b1, 1'b0));

    // R7 idle load clears after one clock
    wr(4'h8, {8'h0, 8'd4, 8'h0, 8'd1});
    rd(4'h0, v); check("R7 busy after write", v[29], 1);
    @(negedge clk);
    rd(4'h0, v); check("R7 idle load next clock", v[29], 0);

    // R7/R8 running shadow update and dropped second write
    set_ch(0, fld(15, 1'b0, 1'b1, 1'b0));
    wr(4'h4, {8'h0, 8'd199, 8'h0, 8'd50});
    repeat (2) @(negedge clk);
    set_ch(0, fld(15, 1'b1, 1'b1, 1'b1));
    wr(4'h4, {8'h0, 8'd99, 8'h0, 8'd10});
    wr(4'h4, {8'h0, 8'd49, 8'h0, 8'd5});
    rd(4'h0, v); check("R7 busy while running", v[28], 1);
    rd(4'h4, v); check("R8 dropped write readback", v, {8'h0, 8'd99, 8'h0, 8'd10});
    n = 0;
    for (int i = 0; i < 400; i++) begin
      rd(4'h0, v);
      if (!v[28]) break;
      n++;
      @(negedge clk);
    end
    check("R7 clears at boundary", (n > 150 && n < 200) ? 1 : 0, 1);
    count_lvl(0, 100, 1'b1, n); check("R8 waveform uses accepted value", n, 10);

    // R11 both channels running with different settings
    set_ch(0, fld(15, 1'b0, 1'b1, 1'b0));
    set_ch(1, fld(15, 1'b0, 1'b0, 1'b0));
    wr(4'h4, {8'h0, 8'd11, 8'h0, 8'd4});
    wr(4'h8, {8'h0, 8'd6, 8'h0, 8'd5});
    repeat (2) @(negedge clk);
    ctlv[9:0] = fld(15, 1'b1, 1'b1, 1'b1);
    ctlv[24:15] = fld(0, 1'b1, 1'b0, 1'b1);
    wr(4'h0, ctlv);
    count_lvl(0, 12 * 7 * 10, 1'b1, n); check("R11 ch0 beside ch1", n, 4 * 7 * 10);
    count_lvl(1, 7 * 120, 1'b0, n); check("R11 ch1 beside ch0", n, 5 * 120);

    // random mix of R4/R5/R9
    for (int k = 0; k < 24; k++) begin
      ch = $urandom_range(1, 0);
      if ($urandom_range(3, 0) == 0) begin
        code = $urandom_range(4, 0);
        p = $urandom_range(7, 0);
      end else begin
        code = 15;
        p = $urandom_range(255, 0);
      end
      d = $urandom_range(255, 0);
      run_case("R4 random", ch, code, p, d, 1'($urandom_range(1, 0)));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule